// File: doc/BRIEF.md
# Grouped Signed Byte Dot-Product Accumulator

This datapath folds signed byte products into a vector of 32-bit accumulator lanes. Two packed byte operands arrive together with a packed accumulator vector. The bytes are taken in consecutive groups of four. Each group supplies one lane: the four byte pairs of that group are multiplied, the products are summed, and the sum is added to the lane's accumulator. The arrangement can be read as a small matrix of rows of length four, with one row-wise dot product per lane.

The parameter `WIDE` selects the operand width. With `WIDE=1` the operands are 128 bits wide, giving 16 bytes and 4 lanes. With `WIDE=0` they are 64 bits wide, giving 8 bytes and 2 lanes. A valid strobe goes with the inputs. One register stage later the result appears with its own valid strobe.

Top module: `gdot_acc`

## Requirements
- R1: After reset is asserted (rst_n low), `res_vld` is 0. It stays 0 until a beat is accepted.
- R2: `res_vld` in cycle n+1 equals `op_vld` in cycle n, for any pattern of valid strobes.
- R3: Byte k (k = 0..3) of group i sits at bits 8*(4*i+k)+7 down to 8*(4*i+k) of `op_x` and of `op_y`. Accumulator lane i sits at bits 32*i+31 down to 32*i of `op_acc`. Result lane i sits at the same bits of `res`.
- R4: Every byte is a two's-complement signed value in the range -128 to 127.
- R5: For each lane i, `res` lane i equals `op_acc` lane i plus the sum over k of x[i][k]*y[i][k]. The result is registered from the beat that has `op_vld` high.
- R6: The lane addition wraps modulo 2^32. It does not saturate and raises no flag.
- R7: Each lane uses only its own group of bytes and its own accumulator. A change in any other group leaves the lane unchanged.
- R8: When `op_vld` is low, `res` keeps its previous value.
- R9: `WIDE` selects 4 lanes over 16 bytes (128-bit operands) or 2 lanes over 8 bytes (64-bit operands).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Input beat valid |
| op_acc | input | 32*LANES | Packed accumulator lanes |
| op_x | input | 32*LANES | Packed signed bytes, first operand |
| op_y | input | 32*LANES | Packed signed bytes, second operand |
| res_vld | output | 1 | Result valid, one cycle after `op_vld` |
| res | output | 32*LANES | Packed result lanes |

## Verification
The bench fills every byte with -128, which gives a product of +16384 per pair, and then mixes -128 with 127 to give products of -16256. A design that zero-extends the bytes gets both of these wrong, and a design that sign-extends only one operand also disagrees with the model.

Wrap-around is tested with accumulators near 0x7FFFFFFF and 0x80000000. A design that saturates at those values, or that widens and truncates in the wrong place, fails these cases.

A one-hot test puts data in a single group at a time. A design with swapped byte or lane positions shows a value in the wrong lane.

Gaps in the valid strobe show whether the result is held while `op_vld` is low and whether the valid output is delayed by exactly one cycle.

// File: rtl/gdot_pkg.sv
package gdot_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned GROUP_N = 4;
  localparam int unsigned LANE_W  = 32;
  localparam int unsigned PROD_W  = 2 * BYTE_W;
  localparam int unsigned SUM_W   = PROD_W + $clog2(GROUP_N);

  function automatic int unsigned lanes_for(input bit wide);
    return wide ? 4 : 2;
  endfunction
endpackage

// File: rtl/gdot_group.sv
module gdot_group
  import gdot_pkg::*;
(
  input  logic [GROUP_N*BYTE_W-1:0] grp_x,
  input  logic [GROUP_N*BYTE_W-1:0] grp_y,
  output logic signed [SUM_W-1:0]   grp_sum
);
  logic signed [PROD_W-1:0] prod [GROUP_N];

  for (genvar k = 0; k < GROUP_N; k++) begin : g_mul
    always_comb begin
      prod[k] = $signed(grp_x[k*BYTE_W +: BYTE_W]) * $signed(grp_y[k*BYTE_W +: BYTE_W]);
    end
  end

  always_comb begin
    grp_sum = '0;
    for (int k = 0; k < GROUP_N; k++) begin
      grp_sum = grp_sum + SUM_W'(prod[k]);
    end
  end
endmodule

// File: rtl/gdot_lane.sv
module gdot_lane
  import gdot_pkg::*;
(
  input  logic [LANE_W-1:0]         lane_acc,
  input  logic [GROUP_N*BYTE_W-1:0] lane_x,
  input  logic [GROUP_N*BYTE_W-1:0] lane_y,
  output logic [LANE_W-1:0]         lane_nxt
);
  logic signed [SUM_W-1:0] dot;

  gdot_group u_grp (
    .grp_x   (lane_x),
    .grp_y   (lane_y),
    .grp_sum (dot)
  );

  always_comb begin
    lane_nxt = lane_acc + LANE_W'(dot);
  end
endmodule

// File: rtl/gdot_acc.sv
module gdot_acc
  import gdot_pkg::*;
#(
  parameter bit WIDE = 1'b1,
  localparam int unsigned LANES = lanes_for(WIDE),
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [VEC_W-1:0] op_acc,
  input  logic [VEC_W-1:0] op_x,
  input  logic [VEC_W-1:0] op_y,
  output logic             res_vld,
  output logic [VEC_W-1:0] res
);
  localparam int unsigned GRP_W = GROUP_N * BYTE_W;

  logic [VEC_W-1:0] res_nxt;
  logic             vld_q;
  logic [VEC_W-1:0] res_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    gdot_lane u_lane (
      .lane_acc (op_acc[i*LANE_W +: LANE_W]),
      .lane_x   (op_x[i*GRP_W +: GRP_W]),
      .lane_y   (op_y[i*GRP_W +: GRP_W]),
      .lane_nxt (res_nxt[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= op_vld;
  end

  always_ff @(posedge clk) begin
    if (op_vld) res_q <= res_nxt;
  end

  assign res_vld = vld_q;
  assign res     = res_q;
endmodule

// File: rtl/gdot_acc_chk.sv
module gdot_acc_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_vld,
  input logic [VEC_W-1:0] op_acc,
  input logic             res_vld,
  input logic [VEC_W-1:0] res
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_VLD_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n) seen |-> (res_vld == $past(op_vld))); // R2
  AST_RESET_IDLE:   assert property (@(posedge clk) !seen |-> !res_vld); // R1
  AST_HOLD_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) (seen && !op_vld) |=> $stable(res)); // R8
  AST_NO_X_RESULT:  assert property (@(posedge clk) disable iff (!rst_n) res_vld |-> !$isunknown(res)); // R5
  AST_NO_X_ACC:     assert property (@(posedge clk) disable iff (!rst_n) op_vld |-> !$isunknown(op_acc)); // R3
endmodule

bind gdot_acc gdot_acc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_vld  (op_vld),
  .op_acc  (op_acc),
  .res_vld (res_vld),
  .res     (res)
);

// File: tb/gdot_acc_tb.sv
`timescale 1ns/1ps
module gdot_acc_tb;
  localparam int LANES = 4;
  localparam int VW    = 32 * LANES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_vld = 1'b0;
  logic [VW-1:0] op_acc = '0, op_x = '0, op_y = '0;
  logic          res_vld;
  logic [VW-1:0] res;
  logic [31:0]   m2_res [2];
  logic [63:0]   acc2, x2, y2;
  logic          res_vld2;
  logic [63:0]   res2;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  gdot_acc #(.WIDE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_acc(op_acc),
    .op_x(op_x), .op_y(op_y), .res_vld(res_vld), .res(res)
  );

  gdot_acc #(.WIDE(1'b0)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_acc(acc2),
    .op_x(x2), .op_y(y2), .res_vld(res_vld2), .res(res2)
  );

  assign acc2 = op_acc[63:0];
  assign x2   = op_x[63:0];
  assign y2   = op_y[63:0];

  function automatic logic [31:0] model(input logic [VW-1:0] a, x, y, input int i);
    logic [31:0] s = a[32*i +: 32];
    for (int k = 0; k < 4; k++)
      s = s + 32'($signed(x[8*(4*i+k) +: 8]) * $signed(y[8*(4*i+k) +: 8]));
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [VW-1:0] a, x, y, input string req);
    @(negedge clk);
    op_vld = 1'b1; op_acc = a; op_x = x; op_y = y;
    @(negedge clk);
    op_vld = 1'b0;
    chk({req, " vld"}, 32'(res_vld), 32'd1);
    for (int i = 0; i < LANES; i++) chk(req, res[32*i +: 32], model(a, x, y, i));
    for (int i = 0; i < 2; i++) chk({req, " R9 narrow"}, res2[32*i +: 32], model(a, x, y, i));
  endtask

  task automatic t_reset;
    chk("R1 reset", 32'(res_vld), 32'd0);
    chk("R1 reset narrow", 32'(res_vld2), 32'd0);
  endtask

  task automatic t_extremes;
    beat({4{32'h0000_0010}}, {16{8'h80}}, {16{8'h80}}, "R4 all -128");
    beat('0, {16{8'h80}}, {16{8'h7F}}, "R4 -128x127");
    beat('0, {16{8'h7F}}, {16{8'h7F}}, "R4 127x127");
  endtask

  task automatic t_wrap;
    beat({32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFF0, 32'h7FFF_FFF0},
         {16{8'h80}}, {{8{8'h80}}, {8{8'h7F}}}, "R6 wrap");
  endtask

  task automatic t_onehot;
    for (int g = 0; g < LANES; g++) begin
      logic [VW-1:0] x = '0;
      x[32*g +: 32] = 32'h0403_0201;
      beat({32'd4, 32'd3, 32'd2, 32'd1}, x, {16{8'hFF}}, "R3 R7 onehot");
    end
  endtask

  task automatic t_hold;
    logic [VW-1:0] prev;
    beat({4{32'd9}}, {16{8'h02}}, {16{8'h03}}, "R5 base");
    prev = res;
    @(negedge clk);
    op_acc = '1; op_x = {16{8'h55}}; op_y = {16{8'hAA}};
    @(negedge clk);
    @(negedge clk);
    chk("R8 hold vld", 32'(res_vld), 32'd0);
    for (int i = 0; i < LANES; i++) chk("R8 hold", res[32*i +: 32], prev[32*i +: 32]);
  endtask

  task automatic t_random;
    for (int n = 0; n < 40; n++) begin
      logic [VW-1:0] a, x, y;
      for (int w = 0; w < LANES; w++) begin
        a[32*w +: 32] = $urandom; x[32*w +: 32] = $urandom; y[32*w +: 32] = $urandom;
      end
      beat(a, x, y, "R5 random");
    end
  endtask

  task automatic t_stream;
    @(negedge clk);
    op_vld = 1'b1; op_acc = '0; op_x = {16{8'h01}}; op_y = {16{8'h01}};
    @(negedge clk);
    op_x = {16{8'h02}};
    chk("R2 stream vld", 32'(res_vld), 32'd1);
    chk("R5 stream 1", res[31:0], 32'd4);
    @(negedge clk);
    op_vld = 1'b0;
    chk("R5 stream 2", res[31:0], 32'd8);
    @(negedge clk);
    chk("R2 stream drop", 32'(res_vld), 32'd0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_extremes();
    t_wrap();
    t_onehot();
    t_hold();
    t_stream();
    t_random();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule